// File: doc/BRIEF.md
# Priority Vectored Handler Address Injector

This block sits on the path from a CPU's instruction address bus to program memory. It watches eight active-high interrupt request lines and picks the highest-numbered active one. While the CPU's two-bit state code reports interrupt servicing, it overwrites a three-bit field of the fetch address with that winner's number. Each source therefore lands in its own 16-byte handler slot with no software polling and no vector read. In every other state the address passes through untouched.

The winning number is taken on the first cycle of interrupt servicing and held for the rest of that service period. A request that rises later cannot move the fetch stream into another slot. A separate request output tells the CPU that at least one enabled source is pending. Both outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `hvec_inject`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_out` becomes 0 and `irq_out` becomes 0.
- R2: When `cpu_state` is not 2'b11 (codes 2'b00, 2'b01 and 2'b10 mean normal operation), `addr_out` equals the `cpu_addr` sampled at the previous edge.
- R3: When `cpu_state` is 2'b11 (interrupt servicing), `addr_out[6:4]` carries the binary number of the selected request one cycle later. Every other bit of `addr_out` equals `cpu_addr`.
- R4: Among simultaneously active requests, the highest-numbered one is selected, so `irq_req[7]` always wins.
- R5: If no request is active on the first cycle of interrupt servicing, the number 0 is used.
- R6: The number is fixed on the first cycle of a run of 2'b11 state codes and is reused for every following cycle of that run, whatever the requests do.
- R7: `irq_out` is high one cycle after a cycle in which `irq_en` is high and any `irq_req` bit is high. Otherwise it is low.
- R8: Once the state code leaves 2'b11 and later returns to it, a fresh number is chosen from the requests present on the new first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Address driven by the CPU |
| cpu_state | input | 2 | CPU state code; 2'b11 means interrupt servicing |
| irq_req | input | 8 | Active-high interrupt requests; bit 7 has the highest priority |
| irq_en | input | 1 | Interrupt enable for the request output |
| addr_out | output | 16 | Address presented to memory, registered |
| irq_out | output | 1 | Registered interrupt request to the CPU |

## Verification
Two functions can fall in the same cycle: the request output tracking a newly raised request, and the held slot number ignoring that same request. The bench starts a service period with a low-numbered request. In the next servicing cycle it raises request 7. It then checks that `irq_out` stays high while `addr_out[6:4]` keeps the original number. It also checks the capture cycle itself, where the number chosen on entry must already appear in the first remapped address.

// File: rtl/hvec_pkg.sv
package hvec_pkg;

  typedef enum logic [1:0] {
    CS_FETCH = 2'b00,
    CS_EXEC  = 2'b01,
    CS_DMA   = 2'b10,
    CS_INTR  = 2'b11
  } cpu_state_e;

  function automatic logic is_service(input logic [1:0] code);
    return cpu_state_e'(code) == CS_INTR;
  endfunction

endpackage

// File: rtl/hvec_prio_enc.sv
module hvec_prio_enc #(
  parameter int N_REQ = 8,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // Ascending scan: the last hit, the highest index, is what remains.
  always_comb begin
    idx = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/hvec_idx_hold.sv
module hvec_idx_hold #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_service,
  input  logic [IDX_W-1:0] idx_live,
  output logic [IDX_W-1:0] idx_use
);

  logic             was_service_q;
  logic [IDX_W-1:0] held_q;
  logic             entry;

  assign entry = in_service && !was_service_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_service_q <= 1'b0;
      held_q        <= '0;
    end else begin
      was_service_q <= in_service;
      if (entry) held_q <= idx_live;
    end
  end

  // The first servicing cycle must already carry the winner, so bypass the register.
  assign idx_use = entry ? idx_live : held_q;

endmodule

// File: rtl/hvec_addr_splice.sv
module hvec_addr_splice #(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 3,
  parameter int IDX_LSB = 4
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr_out
);

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b >= IDX_LSB && b < IDX_LSB + IDX_W) begin : g_sub
      assign addr_out[b] = sel ? idx[b-IDX_LSB] : addr_in[b];
    end else begin : g_pass
      assign addr_out[b] = addr_in[b];
    end
  end

endmodule

// File: rtl/hvec_inject.sv
module hvec_inject #(
  parameter int ADDR_W  = 16,
  parameter int N_REQ   = 8,
  parameter int IDX_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_state,
  input  logic [N_REQ-1:0]  irq_req,
  input  logic              irq_en,
  output logic [ADDR_W-1:0] addr_out,
  output logic              irq_out
);
  import hvec_pkg::*;

  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic             in_service;
  logic [IDX_W-1:0] idx_live;
  logic [IDX_W-1:0] idx_use;
  logic             any_req;
  logic [ADDR_W-1:0] addr_next;

  assign in_service = is_service(cpu_state);

  hvec_prio_enc #(.N_REQ(N_REQ)) u_enc (
    .req (irq_req),
    .idx (idx_live),
    .any (any_req)
  );

  hvec_idx_hold #(.IDX_W(IDX_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .in_service (in_service),
    .idx_live   (idx_live),
    .idx_use    (idx_use)
  );

  hvec_addr_splice #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .IDX_LSB (IDX_LSB)
  ) u_splice (
    .sel      (in_service),
    .addr_in  (cpu_addr),
    .idx      (idx_use),
    .addr_out (addr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      irq_out  <= 1'b0;
    end else begin
      addr_out <= addr_next;
      irq_out  <= irq_en && any_req;
    end
  end

endmodule

// File: rtl/hvec_inject_chk.sv
module hvec_inject_chk #(
  parameter int ADDR_W  = 16,
  parameter int N_REQ   = 8,
  parameter int IDX_LSB = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [1:0]        cpu_state,
  input logic [N_REQ-1:0]  irq_req,
  input logic              irq_en,
  input logic [ADDR_W-1:0] addr_out,
  input logic              irq_out
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [ADDR_W-1:0] FIELD = ADDR_W'((1 << IDX_W) - 1) << IDX_LSB;

  logic svc;
  logic prev_svc;
  assign svc = (cpu_state == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) prev_svc <= 1'b0;
    else     prev_svc <= svc;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && !irq_out));

  a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
    !svc |=> addr_out == $past(cpu_addr));

  a_r3_outside_field: assert property (@(posedge clk) disable iff (rst)
    svc |=> (addr_out & ~FIELD) == ($past(cpu_addr) & ~FIELD));

  a_r4_top_wins: assert property (@(posedge clk) disable iff (rst)
    (svc && !prev_svc && irq_req[N_REQ-1]) |=> addr_out[IDX_LSB +: IDX_W] == IDX_W'(N_REQ-1));

  a_r5_none_zero: assert property (@(posedge clk) disable iff (rst)
    (svc && !prev_svc && irq_req == '0) |=> addr_out[IDX_LSB +: IDX_W] == '0);

  a_r6_held: assert property (@(posedge clk) disable iff (rst)
    (svc && prev_svc) |=> $stable(addr_out[IDX_LSB +: IDX_W]));

  a_r7_irq_hi: assert property (@(posedge clk) disable iff (rst)
    (irq_en && |irq_req) |=> irq_out);

  a_r7_irq_lo: assert property (@(posedge clk) disable iff (rst)
    !(irq_en && |irq_req) |=> !irq_out);

endmodule

bind hvec_inject hvec_inject_chk #(
  .ADDR_W  (ADDR_W),
  .N_REQ   (N_REQ),
  .IDX_LSB (IDX_LSB)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_state (cpu_state),
  .irq_req   (irq_req),
  .irq_en    (irq_en),
  .addr_out  (addr_out),
  .irq_out   (irq_out)
);

// File: tb/hvec_inject_tb.sv
module hvec_inject_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [1:0]  cpu_state = 2'b00;
  logic [7:0]  irq_req = '0;
  logic        irq_en = 1'b0;
  logic [15:0] addr_out;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hvec_inject u_dut (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_state (cpu_state),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .addr_out  (addr_out),
    .irq_out   (irq_out)
  );

  function automatic logic [2:0] top_idx(input logic [7:0] r);
    logic [2:0] k = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (r[i]) begin
        k = 3'(i);
        break;
      end
    end
    return k;
  endfunction

  function automatic logic [15:0] slot(input logic [15:0] a, input logic [2:0] k);
    return (a & 16'hFF8F) | (16'(k) << 4);
  endfunction

  task automatic chk16(input string rq, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr_out=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk1(input string rq, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s irq_out=%b expected=%b", rq, act, exp);
    end
  endtask

  // Drive away from the edge, let one edge pass, sample just after it.
  task automatic step(input logic [15:0] a, input logic [1:0] s,
                      input logic [7:0] r, input logic e);
    @(negedge clk);
    cpu_addr = a; cpu_state = s; irq_req = r; irq_en = e;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(16'hABCD, 2'b11, 8'hFF, 1'b1);
    chk16("R1", addr_out, 16'h0000);
    chk1("R1", irq_out, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_passthru;
    step(16'h1234, 2'b00, 8'h80, 1'b1); chk16("R2", addr_out, 16'h1234);
    step(16'hFFFF, 2'b01, 8'h01, 1'b0); chk16("R2", addr_out, 16'hFFFF);
    step(16'h0070, 2'b10, 8'h00, 1'b0); chk16("R2", addr_out, 16'h0070);
  endtask

  task automatic t_each_source;
    for (int i = 0; i < 8; i++) begin
      step(16'h5A5A, 2'b11, 8'(1 << i), 1'b1);
      chk16("R3", addr_out, slot(16'h5A5A, 3'(i)));
      step(16'h0000, 2'b00, 8'h00, 1'b1);
    end
    step(16'hFFFF, 2'b11, 8'h00, 1'b0);
    chk16("R3_R5", addr_out, 16'hFF8F);
    step(16'h0000, 2'b00, 8'h00, 1'b0);
  endtask

  task automatic t_priority;
    logic [7:0] pats [3] = '{8'hA6, 8'h06, 8'h7F};
    for (int i = 0; i < 3; i++) begin
      step(16'h8000, 2'b11, pats[i], 1'b1);
      chk16("R4", addr_out, slot(16'h8000, top_idx(pats[i])));
      step(16'h8000, 2'b00, 8'h00, 1'b1);
    end
  endtask

  task automatic t_none;
    step(16'h4321, 2'b11, 8'h00, 1'b1);
    chk16("R5", addr_out, slot(16'h4321, 3'd0));
    chk1("R5", irq_out, 1'b0);
    step(16'h0000, 2'b00, 8'h00, 1'b0);
  endtask

  task automatic t_hold_reenter;
    step(16'h2000, 2'b11, 8'h02, 1'b1);
    chk16("R6", addr_out, 16'h2010);
    step(16'h2001, 2'b11, 8'h82, 1'b1);
    chk16("R6", addr_out, 16'h2011);
    chk1("R6_R7", irq_out, 1'b1);
    step(16'h2002, 2'b11, 8'h80, 1'b1);
    chk16("R6", addr_out, 16'h2012);
    step(16'h2000, 2'b00, 8'h80, 1'b1);
    chk16("R8", addr_out, 16'h2000);
    step(16'h2000, 2'b11, 8'h80, 1'b1);
    chk16("R8", addr_out, 16'h2070);
    step(16'h0000, 2'b00, 8'h00, 1'b0);
  endtask

  task automatic t_irq;
    step(16'h0000, 2'b00, 8'h10, 1'b0); chk1("R7", irq_out, 1'b0);
    step(16'h0000, 2'b00, 8'h00, 1'b1); chk1("R7", irq_out, 1'b0);
    step(16'h0000, 2'b00, 8'h01, 1'b1); chk1("R7", irq_out, 1'b1);
    step(16'h0000, 2'b00, 8'h00, 1'b1); chk1("R7", irq_out, 1'b0);
  endtask

  initial begin
    t_reset;
    t_passthru;
    t_each_source;
    t_priority;
    t_none;
    t_hold_reenter;
    t_irq;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule